// File: doc/BRIEF.md
# Serial Dot-Matrix Display Chain Write Sequencer

This block is the host-side controller for a daisy chain of serial 5x7 dot-matrix LED display drivers. It takes one command at a time from a requester and converts it into the exact pin sequence the chain expects on its shared bus: register select, active-low chip select, shift clock, the receiver reset line, and a serial data line that feeds the near end of the chain. Every bus edge is generated from the system clock, and the pulse widths and setup intervals are parameters given in nanoseconds. Each one is converted to system-clock cycles and rounded up.

Three commands exist. A frame write streams the whole dot image, 160 bits per device, out of an external frame buffer. The buffer is read through a bit-address / single-bit data port. A control write shifts one configuration byte into every device. An initialisation does the following in order: it pulses the receivers' reset, clears all dots, and writes the brightness word with the wake bit set, so that the display only lights once its image is blank. The sequencer tracks whether the chain has been switched to the mode in which a control byte reaches all devices at once. It shortens control writes to match.

Top module: `dispchain_wr_seq`

## Requirements
- R1: `disp_rs` is set to its target (0 for a frame, 1 for a control byte) at least the register-select setup time before `disp_cs_n` falls, and it does not change while `disp_cs_n` is low.
- R2: While `disp_cs_n` is low, every high phase of `disp_sclk` lasts at least the clock-high minimum and every low phase lasts at least the clock-low minimum. `disp_sdi` does not change in the cycle of a rising `disp_sclk`, and it is settled at least the data setup time before that edge.
- R3: The first rising `disp_sclk` edge comes at least the chip-select setup time after `disp_cs_n` falls. `disp_cs_n` rises no sooner than the chip-select hold time after the last rising edge.
- R4: A frame write (`cmd_op` = 1) gives exactly 160×N_DEV rising edges in one select window. `fb_addr` steps down from 160×N_DEV−1 to 0, one address per edge. The bit read at address k therefore ends at chain position k, with the far device holding the highest positions.
- R5: A transfer ends with `disp_cs_n` rising while `disp_sclk` is high, followed by `disp_sclk` falling. `done` is high for exactly one cycle: the first cycle in which `disp_sclk` is low again. `busy` drops in that same cycle.
- R6: A control write (`cmd_op` = 2) sends `cmd_arg` MSB first. It uses 8×N_DEV rising edges (the byte repeated per device) while the chain is in serial mode, and 8 edges once a committed control-word-1 write has set bit 0.
- R7: When `cmd_arg[7]` = 1 (control word 1), bits 6..2 are sent as zero, whatever their value in `cmd_arg`.
- R8: An initialisation (`cmd_op` = 0) holds `disp_rst_n` low for at least the reset minimum. It then commits 160×N_DEV zero dots, and then commits control word 0 with bit 6 = 1 and bits 5..0 = `cmd_arg[5..0]`. All of this happens within one busy period with a single `done`, and serial mode is assumed afterwards.
- R9: `cmd_valid` has no effect while `busy` is high, and `cmd_op` = 3 is never accepted.
- R10: While `rst_n` is low, `disp_cs_n` = 1, `disp_sclk` = 0, `disp_rst_n` = 1, `busy` = 0 and `done` = 0.
- R11: `busy` is high from the cycle after a command is accepted until `done`, and it is high whenever `disp_cs_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset of the sequencer |
| cmd_valid | input | 1 | Command request, taken when idle |
| cmd_op | input | 2 | 0 initialise, 1 frame write, 2 control write, 3 no operation |
| cmd_arg | input | 8 | Control byte, or brightness bits 5..0 for initialise |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| fb_addr | output | AW | Frame-buffer bit address |
| fb_data | input | 1 | Frame-buffer bit at `fb_addr`, same cycle |
| disp_rst_n | output | 1 | Reset line to the display chain |
| disp_rs | output | 1 | Register select: 0 dots, 1 control |
| disp_cs_n | output | 1 | Active-low chip select |
| disp_sclk | output | 1 | Shift clock, data taken on its rising edge |
| disp_sdi | output | 1 | Serial data into the near end of the chain |

## Verification
The hardest condition to reach is the switch in control-write length. It takes a control-word-1 write with bit 0 set, committed while the chain is still serial, so the very next control byte must use only 8 clocks. A later word-1 write with bit 0 clear, or an initialisation, must then restore 8×N_DEV clocks. The bench reaches this with a directed run of control writes (set, short write, clear, long write) before its random mix. It checks each length against a behavioural model of the device chain that it drives from the bus pins. That model follows each device's mode and routes each device's serial output through the chain. It therefore also shows the shift-register contents a wrong clock count would leave behind.

// File: rtl/dsw_pkg.sv
package dsw_pkg;

   localparam int DOT_BITS = 160;

   typedef enum logic [1:0] {
      OP_INIT  = 2'd0,
      OP_FRAME = 2'd1,
      OP_CTRL  = 2'd2,
      OP_NOP   = 2'd3
   } dsw_op_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RST,
      ST_RS,
      ST_LO,
      ST_HI,
      ST_END
   } dsw_state_e;

   // nanoseconds to clock cycles, rounded up, never below one cycle
   function automatic int ns_to_cyc(input int ns, input int period_ns);
      int c;
      c = (ns + period_ns - 1) / period_ns;
      if (c < 1) c = 1;
      return c;
   endfunction

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/dsw_timer.sv
module dsw_timer #(
   parameter int TW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [TW-1:0] load_val,
   output logic          expired
);

   logic [TW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign expired = (cnt_q == '0);

endmodule

// File: rtl/dsw_bitsrc.sv
module dsw_bitsrc #(
   parameter int N_DEV = 2,
   parameter int AW    = 9
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ctrl_sel,
   input  logic          zero_dots,
   input  logic          sim_mode,
   input  logic [7:0]    ctrl_byte,
   input  logic [AW-1:0] bit_idx,
   input  logic          fb_data,
   output logic [AW-1:0] len_m1,
   output logic          sdi_q
);

   localparam int FRAME_LEN = dsw_pkg::DOT_BITS * N_DEV;
   localparam int CTRL_SER  = 8 * N_DEV;

   logic nxt_bit;

   assign len_m1 = ctrl_sel ? (sim_mode ? AW'(7) : AW'(CTRL_SER - 1))
                            : AW'(FRAME_LEN - 1);

   // the low three index bits walk 7..0 in every byte repeat: MSB first
   always_comb begin
      if (ctrl_sel)       nxt_bit = ctrl_byte[bit_idx[2:0]];
      else if (zero_dots) nxt_bit = 1'b0;
      else                nxt_bit = fb_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) sdi_q <= 1'b0;
      else        sdi_q <= nxt_bit;
   end

endmodule

// File: rtl/dispchain_wr_seq.sv
module dispchain_wr_seq
   import dsw_pkg::*;
#(
   parameter int N_DEV         = 2,
   parameter int SYS_CLK_NS    = 10,
   parameter int T_CLK_HI_NS   = 100,
   parameter int T_CLK_LO_NS   = 100,
   parameter int T_RS_SU_NS    = 10,
   parameter int T_CS_SU_NS    = 55,
   parameter int T_CS_HOLD_NS  = 20,
   parameter int T_DATA_SU_NS  = 10,
   parameter int T_RST_LOW_NS  = 50,
   parameter int AW            = $clog2(DOT_BITS * N_DEV)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cmd_valid,
   input  logic [1:0]    cmd_op,
   input  logic [7:0]    cmd_arg,
   output logic          busy,
   output logic          done,
   output logic [AW-1:0] fb_addr,
   input  logic          fb_data,
   output logic          disp_rst_n,
   output logic          disp_rs,
   output logic          disp_cs_n,
   output logic          disp_sclk,
   output logic          disp_sdi
);

   localparam int DS_C   = ns_to_cyc(T_DATA_SU_NS, SYS_CLK_NS);
   localparam int CEH_C  = ns_to_cyc(T_CS_HOLD_NS, SYS_CLK_NS);
   localparam int CSU_C  = ns_to_cyc(T_CS_SU_NS, SYS_CLK_NS);
   localparam int HI_C   = imax(ns_to_cyc(T_CLK_HI_NS, SYS_CLK_NS), CEH_C);
   localparam int LO_C   = imax(ns_to_cyc(T_CLK_LO_NS, SYS_CLK_NS), DS_C + 1);
   localparam int RS_C   = ns_to_cyc(T_RS_SU_NS, SYS_CLK_NS);
   localparam int LEAD_C = imax(CSU_C, LO_C);
   localparam int RST_C  = ns_to_cyc(T_RST_LOW_NS, SYS_CLK_NS);
   localparam int TMAX   = imax(imax(HI_C, LEAD_C), imax(RS_C, RST_C));
   localparam int TW     = $clog2(TMAX + 1);

   // elaboration-time parameter checks
   generate
      if (N_DEV < 1) begin : g_bad_ndev
         $error("N_DEV must be at least one");
      end
      if (SYS_CLK_NS < 1) begin : g_bad_period
         $error("SYS_CLK_NS must be positive");
      end
      if ((1 << AW) < DOT_BITS * N_DEV) begin : g_bad_aw
         $error("AW too narrow for the dot chain");
      end
   endgenerate

   dsw_state_e state_q, state_d;
   logic          tmr_load, tmr_exp;
   logic [TW-1:0] tmr_val;
   logic [AW-1:0] idx_q, len_m1;
   logic          ctrl_sel_q, zero_q, init_ph_q, sim_q;
   logic [7:0]    byte_q;
   logic [5:0]    bright_q;
   logic          start;
   dsw_op_e       op;

   assign op    = dsw_op_e'(cmd_op);
   assign start = (state_q == ST_IDLE) && cmd_valid && (op != OP_NOP);

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE: if (start)   state_d = (op == OP_INIT) ? ST_RST : ST_RS;
         ST_RST:  if (tmr_exp) state_d = ST_RS;
         ST_RS:   if (tmr_exp) state_d = ST_LO;
         ST_LO:   if (tmr_exp) state_d = ST_HI;
         ST_HI:   if (tmr_exp) state_d = (idx_q == '0) ? ST_END : ST_LO;
         ST_END:  if (tmr_exp) state_d = (init_ph_q && !ctrl_sel_q) ? ST_RS : ST_IDLE;
         default: state_d = ST_IDLE;
      endcase
   end

   always_comb begin
      tmr_load = (state_d != state_q);
      unique case (state_d)
         ST_RST:  tmr_val = TW'(RST_C - 1);
         ST_RS:   tmr_val = TW'(RS_C - 1);
         ST_LO:   tmr_val = (state_q == ST_RS) ? TW'(LEAD_C - 1) : TW'(LO_C - 1);
         ST_HI:   tmr_val = TW'(HI_C - 1);
         ST_END:  tmr_val = TW'(HI_C - 1);
         default: tmr_val = '0;
      endcase
   end

   dsw_timer #(.TW(TW)) tmr_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .expired  (tmr_exp)
   );

   dsw_bitsrc #(.N_DEV(N_DEV), .AW(AW)) bits_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .ctrl_sel  (ctrl_sel_q),
      .zero_dots (zero_q),
      .sim_mode  (sim_q),
      .ctrl_byte (byte_q),
      .bit_idx   (idx_q),
      .fb_data   (fb_data),
      .len_m1    (len_m1),
      .sdi_q     (disp_sdi)
   );

   assign fb_addr = idx_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         busy       <= 1'b0;
         done       <= 1'b0;
         disp_cs_n  <= 1'b1;
         disp_sclk  <= 1'b0;
         disp_rs    <= 1'b0;
         disp_rst_n <= 1'b1;
         ctrl_sel_q <= 1'b0;
         zero_q     <= 1'b0;
         init_ph_q  <= 1'b0;
         sim_q      <= 1'b0;
         byte_q     <= '0;
         bright_q   <= '0;
         idx_q      <= '0;
      end else begin
         state_q <= state_d;
         done    <= 1'b0;
         unique case (state_q)
            ST_IDLE: if (start) begin
               busy <= 1'b1;
               unique case (op)
                  OP_INIT: begin
                     disp_rst_n <= 1'b0;
                     init_ph_q  <= 1'b1;
                     bright_q   <= cmd_arg[5:0];
                     sim_q      <= 1'b0;
                     ctrl_sel_q <= 1'b0;
                     zero_q     <= 1'b1;
                  end
                  OP_FRAME: begin
                     ctrl_sel_q <= 1'b0;
                     zero_q     <= 1'b0;
                     init_ph_q  <= 1'b0;
                     disp_rs    <= 1'b0;
                  end
                  default: begin
                     ctrl_sel_q <= 1'b1;
                     init_ph_q  <= 1'b0;
                     disp_rs    <= 1'b1;
                     byte_q     <= cmd_arg[7] ? {1'b1, 5'b0, cmd_arg[1:0]} : cmd_arg;
                  end
               endcase
            end
            ST_RST: if (tmr_exp) begin
               disp_rst_n <= 1'b1;
               disp_rs    <= 1'b0;
            end
            ST_RS: if (tmr_exp) begin
               disp_cs_n <= 1'b0;
               idx_q     <= len_m1;
            end
            ST_LO: if (tmr_exp) disp_sclk <= 1'b1;
            ST_HI: if (tmr_exp) begin
               if (idx_q == '0) begin
                  disp_cs_n <= 1'b1;
               end else begin
                  disp_sclk <= 1'b0;
                  idx_q     <= idx_q - 1'b1;
               end
            end
            ST_END: if (tmr_exp) begin
               disp_sclk <= 1'b0;
               if (ctrl_sel_q && byte_q[7]) sim_q <= byte_q[0];
               if (init_ph_q && !ctrl_sel_q) begin
                  ctrl_sel_q <= 1'b1;
                  zero_q     <= 1'b0;
                  disp_rs    <= 1'b1;
                  byte_q     <= {2'b01, bright_q};
               end else begin
                  busy      <= 1'b0;
                  done      <= 1'b1;
                  init_ph_q <= 1'b0;
               end
            end
            default: ;
         endcase
      end
   end

   // ---------------- checker counters and assertions ----------------
   logic [31:0] hi_run, lo_run, cs_run, rst_run;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hi_run  <= '0;
         lo_run  <= '1;
         cs_run  <= '0;
         rst_run <= '0;
      end else begin
         if (disp_sclk)   hi_run <= (hi_run != '1) ? hi_run + 1 : hi_run; else hi_run <= '0;
         if (!disp_sclk)  lo_run <= (lo_run != '1) ? lo_run + 1 : lo_run; else lo_run <= '0;
         if (!disp_cs_n)  cs_run <= (cs_run != '1) ? cs_run + 1 : cs_run; else cs_run <= '0;
         if (!disp_rst_n) rst_run <= rst_run + 1; else rst_run <= '0;
      end
   end

   // R1
   rs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !disp_cs_n |-> $stable(disp_rs));
   // R2
   sclk_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(disp_sclk) |-> hi_run >= 32'(HI_C));
   // R2
   sclk_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(disp_sclk) |-> lo_run >= 32'(LO_C));
   // R2
   sdi_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(disp_sclk) |-> $stable(disp_sdi));
   // R3
   cs_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(disp_sclk) |-> (!disp_cs_n && cs_run >= 32'(CSU_C)));
   // R5
   cs_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(disp_cs_n) |-> (disp_sclk && hi_run >= 32'(CEH_C)));
   // R5
   done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ($fell(disp_sclk) && disp_cs_n && !busy));
   // R8
   rst_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(disp_rst_n) |-> rst_run >= 32'(RST_C));
   // R11
   busy_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !disp_cs_n |-> busy);

endmodule

// File: tb/dispchain_wr_seq_tb_top.sv
module dispchain_wr_seq_tb_top;

   localparam int N    = 2;
   localparam int TOT  = 160 * N;
   localparam int PER  = 10;
   localparam int AW   = $clog2(TOT);
   localparam int HI_MIN   = (100 + PER - 1) / PER;
   localparam int LO_MIN   = (100 + PER - 1) / PER;
   localparam int LEAD_MIN = (55 + PER - 1) / PER;
   localparam int TAIL_MIN = (20 + PER - 1) / PER;
   localparam int DS_MIN   = (10 + PER - 1) / PER;
   localparam int RS_MIN   = (10 + PER - 1) / PER;
   localparam int RST_MIN  = (50 + PER - 1) / PER;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cmd_valid = 1'b0;
   logic [1:0] cmd_op = 2'd0;
   logic [7:0] cmd_arg = 8'd0;
   logic busy, done, fb_data, disp_rst_n, disp_rs, disp_cs_n, disp_sclk, disp_sdi;
   logic [AW-1:0] fb_addr;
   logic [TOT-1:0] fb_mem;

   always #5 clk = ~clk;
   assign fb_data = fb_mem[fb_addr];

   dispchain_wr_seq #(.N_DEV(N), .SYS_CLK_NS(PER)) dut_i (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .cmd_arg(cmd_arg), .busy(busy), .done(done), .fb_addr(fb_addr),
      .fb_data(fb_data), .disp_rst_n(disp_rst_n), .disp_rs(disp_rs),
      .disp_cs_n(disp_cs_n), .disp_sclk(disp_sclk), .disp_sdi(disp_sdi)
   );

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   // ---------------- behavioural model of the device chain ----------------
   logic [TOT-1:0] chain = '1;
   logic [TOT-1:0] latch = '1;
   logic [7:0] csr [N];
   logic [6:0] w0 [N];
   logic [6:0] w1 [N];
   logic pclk = 0, pcs = 1, prst = 1, prs = 0, psdi = 0;
   logic rs_lat = 0, last_rs = 0;
   bit armed = 0, first_rise = 0, rs_moved = 0;
   int rises_total = 0, win_rises = 0, addr_err = 0, rst_pulses = 0;
   int hi_run = 0, lo_run = 0, cs_run = 0, since_rise = 0, rst_run = 0, rs_run = 0, sdi_run = 0;
   int min_hi = 1000, min_lo = 1000, min_lead = 1000, min_tail = 1000;
   int min_rst = 1000, min_rs = 1000, min_ds = 1000;

   initial begin
      for (int d = 0; d < N; d++) begin
         csr[d] = '1; w0[d] = '1; w1[d] = '1;
      end
   end

   always @(negedge clk) begin
      logic din_d, nd;
      if (rst_n) begin
         // step 1: edge events, using run lengths up to the previous sample
         if (!prst && disp_rst_n) begin
            rst_pulses++;
            if (rst_run < min_rst) min_rst = rst_run;
         end
         if (pcs && !disp_cs_n) begin
            rs_lat = disp_rs; armed = 1; first_rise = 1; cs_run = 0; win_rises = 0;
            rs_moved = 0;
            if (rs_run < min_rs) min_rs = rs_run;
         end
         if (!disp_cs_n && (disp_rs != prs)) rs_moved = 1;
         if (!pclk && disp_sclk && !disp_cs_n) begin
            if (first_rise && cs_run < min_lead) min_lead = cs_run;
            first_rise = 0;
            if (lo_run < min_lo) min_lo = lo_run;
            if (sdi_run < min_ds) min_ds = sdi_run;
            if (!rs_lat) begin
               if (fb_addr != AW'(TOT - 1 - win_rises)) addr_err++;
               chain = {chain[TOT-2:0], disp_sdi};
            end else begin
               din_d = disp_sdi;
               for (int d = 0; d < N; d++) begin
                  nd = w1[d][0] ? din_d : csr[d][7];
                  csr[d] = {csr[d][6:0], din_d};
                  din_d = nd;
               end
            end
            rises_total++; win_rises++; since_rise = 0;
         end
         if (pclk && !disp_sclk && !disp_cs_n && hi_run < min_hi) min_hi = hi_run;
         if (!pcs && disp_cs_n) begin
            chk(disp_sclk == 1'b1, "R5 cs rises with sclk high", disp_sclk, 1);
            if (since_rise < min_tail) min_tail = since_rise;
         end
         if (armed && disp_cs_n && !disp_sclk) begin
            armed = 0;
            last_rs = rs_lat;
            chk(!rs_moved, "R1 rs stable in window", rs_moved, 0);
            if (!rs_lat) latch = chain;
            else for (int d = 0; d < N; d++)
               if (csr[d][7]) w1[d] = csr[d][6:0]; else w0[d] = csr[d][6:0];
         end
         if (done) chk(pclk && !disp_sclk && disp_cs_n, "R5 done in first low cycle",
                       {pclk, disp_sclk, disp_cs_n}, 3'b101);
         if (!disp_cs_n) chk(busy, "R11 busy during window", busy, 1);
         // step 2: run lengths
         if (!disp_rst_n) begin
            rst_run++;
            for (int d = 0; d < N; d++) begin w0[d] = '0; w1[d] = '0; end
         end else rst_run = 0;
         if (disp_sclk) hi_run++; else hi_run = 0;
         if (!disp_sclk) lo_run++; else lo_run = 0;
         if (!disp_cs_n) cs_run++;
         since_rise++;
         if (disp_rs == prs) rs_run++; else rs_run = 1;
         if (disp_sdi == psdi) sdi_run++; else sdi_run = 1;
      end
      pclk = disp_sclk; pcs = disp_cs_n; prst = disp_rst_n; prs = disp_rs; psdi = disp_sdi;
   end

   // ---------------- expected values ----------------
   logic [6:0] exp_w0 = '0, exp_w1 = '0;
   int last_rises = 0;

   function automatic int ctrl_len(input logic [6:0] word1);
      return word1[0] ? 8 : 8 * N;
   endfunction

   task automatic fill_fb();
      for (int i = 0; i < TOT; i += 32) begin
         logic [31:0] r;
         r = $urandom;
         for (int j = 0; j < 32; j++) if (i + j < TOT) fb_mem[i+j] = r[j];
      end
   endtask

   task automatic run_cmd(input logic [1:0] op, input logic [7:0] arg);
      int r0;
      @(negedge clk); #1;
      r0 = rises_total;
      cmd_valid = 1; cmd_op = op; cmd_arg = arg;
      @(negedge clk); #1;
      cmd_valid = 0;
      chk(busy, "R11 busy after accept", busy, 1);
      while (!done) begin @(negedge clk); #1; end
      chk(!busy, "R5 busy drops with done", busy, 0);
      last_rises = rises_total - r0;
   endtask

   task automatic check_words(input string req);
      for (int d = 0; d < N; d++) begin
         chk(w0[d] == exp_w0, req, w0[d], exp_w0);
         chk(w1[d] == exp_w1, req, w1[d], exp_w1);
      end
   endtask

   task automatic do_ctrl(input logic [7:0] arg, input string req);
      int exp_r;
      exp_r = ctrl_len(exp_w1);
      run_cmd(2'd2, arg);
      if (arg[7]) exp_w1 = {5'b0, arg[1:0]}; else exp_w0 = arg[6:0];
      chk(last_rises == exp_r, req, last_rises, exp_r);
      chk(last_rs == 1'b1, "R1 rs high for control", last_rs, 1);
      check_words(req);
   endtask

   task automatic do_frame(input string req);
      int ae0;
      fill_fb();
      ae0 = addr_err;
      run_cmd(2'd1, 8'h00);
      chk(last_rises == TOT, req, last_rises, TOT);
      chk(last_rs == 1'b0, "R1 rs low for dots", last_rs, 0);
      chk(addr_err == ae0, "R4 fb_addr descending", addr_err - ae0, 0);
      chk(latch == fb_mem, req, $countones(latch ^ fb_mem), 0);
   endtask

   initial begin
      logic [5:0] br;
      int r0;
      void'($urandom(32'h1D5E_7A01));
      fb_mem = '0;
      repeat (4) @(negedge clk);
      #1;
      // R10 reset state
      chk(disp_cs_n == 1'b1, "R10 cs idle", disp_cs_n, 1);
      chk(disp_sclk == 1'b0, "R10 sclk idle", disp_sclk, 0);
      chk(disp_rst_n == 1'b1, "R10 reset line idle", disp_rst_n, 1);
      chk(!busy && !done, "R10 busy/done low", {busy, done}, 0);
      rst_n = 1;

      // R8 initialisation
      br = 6'($urandom);
      run_cmd(2'd0, {2'b11, br});
      exp_w0 = {1'b1, br}; exp_w1 = '0;
      chk(rst_pulses == 1, "R8 one reset pulse", rst_pulses, 1);
      chk(min_rst >= RST_MIN, "R8 reset width", min_rst, RST_MIN);
      chk(latch == '0, "R8 dots cleared", $countones(latch), 0);
      chk(last_rises == TOT + 8 * N, "R8 init clock count", last_rises, TOT + 8 * N);
      check_words("R8 wake word");

      do_frame("R4 frame a");
      do_frame("R4 frame b");

      // R6 serial then simultaneous lengths, R7 reserved bits
      do_ctrl({1'b0, 7'($urandom)}, "R6 serial word0");
      do_ctrl(8'hFF, "R7 word1 reserved zero");
      do_ctrl({1'b0, 7'($urandom)}, "R6 simultaneous word0");
      do_ctrl(8'hFC, "R7 word1 back to serial");
      do_ctrl({1'b0, 7'($urandom)}, "R6 serial again");

      // R9 command while busy is dropped
      fill_fb();
      @(negedge clk); #1;
      r0 = rises_total;
      cmd_valid = 1; cmd_op = 2'd1; cmd_arg = 8'h00;
      @(negedge clk); #1;
      cmd_valid = 0;
      repeat (40) @(negedge clk);
      #1;
      cmd_valid = 1; cmd_op = 2'd2; cmd_arg = 8'h81;
      @(negedge clk); #1;
      cmd_valid = 0;
      while (!done) begin @(negedge clk); #1; end
      chk(rises_total - r0 == TOT, "R9 busy command ignored", rises_total - r0, TOT);
      repeat (30) @(negedge clk);
      #1;
      chk(!busy && disp_cs_n, "R9 no queued transfer", {busy, disp_cs_n}, 1);
      chk(rises_total - r0 == TOT, "R9 no extra clocks", rises_total - r0, TOT);
      check_words("R9 control words untouched");
      chk(latch == fb_mem, "R4 frame under busy", $countones(latch ^ fb_mem), 0);

      // R9 op 3 never accepted
      r0 = rises_total;
      cmd_valid = 1; cmd_op = 2'd3;
      @(negedge clk); #1;
      cmd_valid = 0;
      repeat (20) @(negedge clk);
      #1;
      chk(!busy && rises_total == r0, "R9 op 3 ignored", busy, 0);

      // constrained random mix
      for (int k = 0; k < 8; k++) begin
         int sel;
         logic [7:0] a;
         sel = int'($urandom_range(0, 4));
         a = 8'($urandom);
         if (sel == 0) do_frame("R4 random frame");
         else do_ctrl(a, a[7] ? "R7 random word1" : "R6 random word0");
      end

      // R2 / R3 timing minima over the whole run
      chk(min_hi >= HI_MIN, "R2 sclk high width", min_hi, HI_MIN);
      chk(min_lo >= LO_MIN, "R2 sclk low width", min_lo, LO_MIN);
      chk(min_ds >= DS_MIN, "R2 data setup", min_ds, DS_MIN);
      chk(min_lead >= LEAD_MIN, "R3 cs to first rise", min_lead, LEAD_MIN);
      chk(min_tail >= TAIL_MIN, "R3 last rise to cs rise", min_tail, TAIL_MIN);
      chk(min_rs >= RS_MIN, "R1 rs setup", min_rs, RS_MIN);

      if (!finished) begin
         finished = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule